// File: doc/BRIEF.md
# Segmented Transfer-Curve Corrector for Overlay Video

This block reshapes the brightness response of an overlay video stream. Each pixel carries three 10-bit colour components, and all three pass through the same piecewise-linear curve. The 10-bit input range is cut into 18 segments. Each segment has its own programmable gain and base level, so a driver can load an approximation of any monotonic or non-monotonic transfer function.

The segments are narrow at the dark end, where the eye is most sensitive, and uniform above it. Segments 0 to 3 cover codes 0x000-0x00F, 0x010-0x01F, 0x020-0x03F and 0x040-0x07F. Fourteen segments of 64 codes each then run from 0x080 to 0x3FF. The input code alone selects the segment.

The block takes one pixel per cycle and produces the corrected pixel two cycles later. A single write port loads one segment word at a time. The parameter `FULL_SET` selects between two variants. The full variant has all 18 segment registers writable. The reduced variant keeps only the four narrow low segments and the two top segments writable, and fixes the middle segments at their power-on values.

Top module: `gamma_curve_pwl`

## Requirements
- R1: The segment index is 0 for codes 0x000-0x00F, 1 for 0x010-0x01F, 2 for 0x020-0x03F and 3 for 0x040-0x07F. For a code x of 0x080 or more the index is 4 + (x - 0x080)/64, so 0x3C0-0x3FF is index 17. The segment start is the lowest code of that range.
- R2: A segment word is 32 bits. Bits 31:16 hold an unsigned slope with 8 fractional bits, so 0x100 is a gain of one. Bits 15:0 hold an unsigned offset.
- R3: Each output component equals offset + floor((x - start) * slope / 256), using the slope and offset of the segment that x falls in.
- R4: A result above 1023 is clamped to 1023.
- R5: After reset every segment has slope 0x100. The offsets of segments 0-3 are 0x000, 0x020, 0x040 and 0x080. Segment k >= 4 has offset 0x100 * ((k - 4)/2 + 1), which gives 0x700 for segments 16 and 17.
- R6: A segment write is seen by a pixel presented in the cycle after the write. A pixel presented in the same cycle as the write still uses the previous value.
- R7: A write to index 18 or above changes no segment.
- R8: With FULL_SET = 0, writes to segments 4-15 are ignored and those segments keep their reset values. Segments 0-3, 16 and 17 stay writable.
- R9: pix_valid_o is pix_valid_i delayed by exactly two clock cycles, and carries the result of that pixel.
- R10: While pix_valid_o is low, pix_o holds its last value.
- R11: The three components, packed as component c in bits [10c+9:10c], use one shared curve and are computed independently. Equal inputs give equal outputs.
- R12: During reset and in the two cycles after it, pix_valid_o is low, and pix_o is zero until the first valid pixel leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| pix_valid_i | input | 1 | An input pixel is present this cycle |
| pix_i | input | 30 | Three 10-bit components; component c is in bits [10c+9:10c] |
| cfg_we_i | input | 1 | Segment register write strobe |
| cfg_sel_i | input | 5 | Index of the segment to write |
| cfg_wdata_i | input | 32 | Segment word: slope in 31:16, offset in 15:0 |
| pix_valid_o | output | 1 | An output pixel is present this cycle |
| pix_o | output | 30 | Corrected components, packed like pix_i |

## Verification
Four properties are checked on every cycle:
- the two-cycle delay of the valid flag,
- the frozen output while no pixel leaves,
- the quiet output in the first cycles after reset,
- identical results for identical components.

Other behaviours can only be shown by the bench's scenarios, because they depend on the curve's contents:
- the exact segment boundaries and the arithmetic,
- clamping at the top code,
- the reset curve,
- the point at which a write takes effect,
- ignored writes, both out of range and to the fixed middle segments of the reduced variant.

The bench runs both variants side by side for these scenarios.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;

    localparam int unsigned PIX_W    = 10;
    localparam int unsigned SEG_N    = 18;
    localparam int unsigned IDX_W    = $clog2(SEG_N);
    localparam int unsigned SLOPE_W  = 16;
    localparam int unsigned OFS_W    = 16;
    localparam int unsigned WORD_W   = SLOPE_W + OFS_W;
    localparam int unsigned FRAC_W   = 8;
    localparam int unsigned NARROW_N = 4;
    localparam int unsigned WIDE_LOG = 6;
    localparam int unsigned TOP_KEEP = 2;

    // slope sits in the upper half so a raw word casts straight in
    typedef struct packed {
        logic [SLOPE_W-1:0] slope;
        logic [OFS_W-1:0]   ofs;
    } seg_cfg_t;

    function automatic seg_cfg_t seg_default(int unsigned idx);
        seg_cfg_t r;
        r.slope = SLOPE_W'(1 << FRAC_W);
        if (idx == 0)
            r.ofs = '0;
        else if (idx < NARROW_N)
            r.ofs = OFS_W'(16 << idx);
        else
            r.ofs = OFS_W'((((idx - NARROW_N) / 2) + 1) << 8);
        return r;
    endfunction

    function automatic logic seg_present(int unsigned idx, bit full);
        return full || (idx < NARROW_N) || (idx >= SEG_N - TOP_KEEP);
    endfunction

endpackage

// File: rtl/gamma_seg_bank.sv
module gamma_seg_bank
    import gamma_pwl_pkg::*;
#(
    parameter bit FULL_SET = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  sel_i,
    input  logic [WORD_W-1:0] wdata_i,
    output seg_cfg_t          cfg_o [SEG_N]
);

    seg_cfg_t bank_d [SEG_N];
    seg_cfg_t bank_q [SEG_N];

    always_comb begin
        bank_d = bank_q;
        if (we_i && (32'(sel_i) < SEG_N) && seg_present(32'(sel_i), FULL_SET))
            bank_d[sel_i] = seg_cfg_t'(wdata_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(SEG_N); i++)
                bank_q[i] <= seg_default(i);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign cfg_o = bank_q;

endmodule

// File: rtl/gamma_seg_lookup.sv
module gamma_seg_lookup
    import gamma_pwl_pkg::*;
(
    input  logic [PIX_W-1:0] pix_i,
    input  seg_cfg_t         cfg_i [SEG_N],
    output logic [PIX_W-1:0] delta_o,
    output seg_cfg_t         cfg_o
);

    logic [IDX_W-1:0] idx;
    logic [PIX_W-1:0] base;

    // priority on the upper bits: wide region first, then narrow ones
    always_comb begin
        if (pix_i[PIX_W-1:WIDE_LOG+1] != '0) begin
            idx  = IDX_W'(pix_i[PIX_W-1:WIDE_LOG]) + IDX_W'(NARROW_N - 2);
            base = {pix_i[PIX_W-1:WIDE_LOG], WIDE_LOG'(0)};
        end else if (pix_i[WIDE_LOG]) begin
            idx  = IDX_W'(3);
            base = PIX_W'(64);
        end else if (pix_i[WIDE_LOG-1]) begin
            idx  = IDX_W'(2);
            base = PIX_W'(32);
        end else if (pix_i[WIDE_LOG-2]) begin
            idx  = IDX_W'(1);
            base = PIX_W'(16);
        end else begin
            idx  = '0;
            base = '0;
        end
        delta_o = pix_i - base;
        cfg_o   = cfg_i[idx];
    end

endmodule

// File: rtl/gamma_chan_mac.sv
module gamma_chan_mac
    import gamma_pwl_pkg::*;
(
    input  logic [PIX_W-1:0] delta_i,
    input  seg_cfg_t         cfg_i,
    output logic [PIX_W-1:0] res_o
);

    localparam int unsigned PROD_W = PIX_W + SLOPE_W;
    localparam int unsigned SUM_W  = PROD_W - FRAC_W + 1;
    localparam logic [SUM_W-1:0] TOP = SUM_W'((1 << PIX_W) - 1);

    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;

    always_comb begin
        prod  = PROD_W'(delta_i) * PROD_W'(cfg_i.slope);
        sum   = SUM_W'(prod >> FRAC_W) + SUM_W'(cfg_i.ofs);
        res_o = (sum > TOP) ? TOP[PIX_W-1:0] : sum[PIX_W-1:0];
    end

endmodule

// File: rtl/gamma_curve_pwl.sv
module gamma_curve_pwl
    import gamma_pwl_pkg::*;
#(
    parameter bit          FULL_SET = 1'b1,
    parameter int unsigned CH_N     = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_valid_i,
    input  logic [CH_N*PIX_W-1:0] pix_i,
    input  logic                  cfg_we_i,
    input  logic [IDX_W-1:0]      cfg_sel_i,
    input  logic [WORD_W-1:0]     cfg_wdata_i,
    output logic                  pix_valid_o,
    output logic [CH_N*PIX_W-1:0] pix_o
);

    typedef struct packed {
        logic                       vld;
        logic [CH_N-1:0][PIX_W-1:0] delta;
        seg_cfg_t [CH_N-1:0]        cfg;
    } stage1_t;

    typedef struct packed {
        logic                       vld;
        logic [CH_N-1:0][PIX_W-1:0] pix;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t                      pipe_d, pipe_q;
    seg_cfg_t                   bank [SEG_N];
    logic [CH_N-1:0][PIX_W-1:0] lk_delta;
    seg_cfg_t [CH_N-1:0]        lk_cfg;
    logic [CH_N-1:0][PIX_W-1:0] mac_res;

    gamma_seg_bank #(.FULL_SET(FULL_SET)) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .sel_i   (cfg_sel_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (bank)
    );

    for (genvar c = 0; c < int'(CH_N); c++) begin : g_chan
        gamma_seg_lookup i_lookup (
            .pix_i   (pix_i[c*PIX_W +: PIX_W]),
            .cfg_i   (bank),
            .delta_o (lk_delta[c]),
            .cfg_o   (lk_cfg[c])
        );
        gamma_chan_mac i_mac (
            .delta_i (pipe_q.s1.delta[c]),
            .cfg_i   (pipe_q.s1.cfg[c]),
            .res_o   (mac_res[c])
        );
    end

    always_comb begin
        pipe_d        = pipe_q;
        pipe_d.s1.vld = pix_valid_i;
        if (pix_valid_i) begin
            pipe_d.s1.delta = lk_delta;
            pipe_d.s1.cfg   = lk_cfg;
        end
        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld)
            pipe_d.s2.pix = mac_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    assign pix_valid_o = pipe_q.s2.vld;
    assign pix_o       = pipe_q.s2.pix;

endmodule

// File: rtl/gamma_curve_pwl_chk.sv
module gamma_curve_pwl_chk
    import gamma_pwl_pkg::*;
#(
    parameter int unsigned CH_N = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pix_valid_i,
    input logic [CH_N*PIX_W-1:0] pix_i,
    input logic                  pix_valid_o,
    input logic [CH_N*PIX_W-1:0] pix_o
);

    logic [1:0]      cyc_q;
    logic [CH_N-1:0] in_eq, out_eq;
    logic            in_same, out_same;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= '0;
        else if (cyc_q != 2'd3)
            cyc_q <= cyc_q + 2'd1;
    end

    for (genvar c = 0; c < int'(CH_N); c++) begin : g_eq
        assign in_eq[c]  = (pix_i[c*PIX_W +: PIX_W] == pix_i[PIX_W-1:0]);
        assign out_eq[c] = (pix_o[c*PIX_W +: PIX_W] == pix_o[PIX_W-1:0]);
    end
    assign in_same  = &in_eq;
    assign out_same = &out_eq;

    assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 2'd2) |-> (pix_valid_o == $past(pix_valid_i, 2)));

    assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q >= 2'd1) && !pix_valid_o) |-> $stable(pix_o));

    assert_shared_curve_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((cyc_q >= 2'd2) && pix_valid_o && $past(in_same, 2)) |-> out_same);

    assert_quiet_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q < 2'd2) |-> !pix_valid_o);

endmodule

bind gamma_curve_pwl gamma_curve_pwl_chk #(.CH_N(CH_N)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid_i (pix_valid_i),
    .pix_i       (pix_i),
    .pix_valid_o (pix_valid_o),
    .pix_o       (pix_o)
);

// File: tb/test_gamma_curve_pwl.sv
module test_gamma_curve_pwl;

    localparam int CLK_PERIOD = 10;
    localparam int PW   = 10;
    localparam int CH   = 3;
    localparam int BW   = PW * CH;
    localparam int NSEG = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          vin = 1'b0;
    logic [BW-1:0] pin = '0;
    logic          we = 1'b0;
    logic [4:0]    sel = '0;
    logic [31:0]   wd = '0;
    logic          vo_f, vo_l;
    logic [BW-1:0] po_f, po_l;

    int compared = 0;
    int mismatched = 0;
    int slope_m [2][NSEG];
    int ofs_m   [2][NSEG];
    logic [BW-1:0] stim [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_curve_pwl #(.FULL_SET(1'b1), .CH_N(CH)) i_gamma_curve_pwl (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(vin), .pix_i(pin),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
        .pix_valid_o(vo_f), .pix_o(po_f));

    gamma_curve_pwl #(.FULL_SET(1'b0), .CH_N(CH)) i_gamma_curve_pwl_lite (
        .clk(clk), .rst_n(rst_n), .pix_valid_i(vin), .pix_i(pin),
        .cfg_we_i(we), .cfg_sel_i(sel), .cfg_wdata_i(wd),
        .pix_valid_o(vo_l), .pix_o(po_l));

    function automatic int seg_idx(int x);
        if (x < 16)  return 0;
        if (x < 32)  return 1;
        if (x < 64)  return 2;
        if (x < 128) return 3;
        return 4 + (x - 128) / 64;
    endfunction

    function automatic int seg_start(int i);
        case (i)
            0: return 0;
            1: return 16;
            2: return 32;
            3: return 64;
            default: return 128 + (i - 4) * 64;
        endcase
    endfunction

    function automatic logic [BW-1:0] expect_bus(logic [BW-1:0] p, int m);
        logic [BW-1:0] r;
        for (int c = 0; c < CH; c++) begin
            int x, i, v;
            x = int'(p[c*PW +: PW]);
            i = seg_idx(x);
            v = ofs_m[m][i] + ((x - seg_start(i)) * slope_m[m][i]) / 256;
            if (v > 1023) v = 1023;
            r[c*PW +: PW] = v[PW-1:0];
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < NSEG; i++) begin
                slope_m[m][i] = 256;
                if (i == 0)      ofs_m[m][i] = 0;
                else if (i == 1) ofs_m[m][i] = 32;
                else if (i == 2) ofs_m[m][i] = 64;
                else if (i == 3) ofs_m[m][i] = 128;
                else             ofs_m[m][i] = 256 * ((i - 4) / 2 + 1);
            end
    endtask

    task automatic model_write(int idx, logic [31:0] d);
        if (idx < NSEG) begin
            slope_m[0][idx] = int'(d[31:16]);
            ofs_m[0][idx]   = int'(d[15:0]);
            if (idx < 4 || idx >= 16) begin
                slope_m[1][idx] = int'(d[31:16]);
                ofs_m[1][idx]   = int'(d[15:0]);
            end
        end
    endtask

    task automatic cfg_write(int idx, logic [31:0] d);
        @(negedge clk);
        we  = 1'b1;
        sel = idx[4:0];
        wd  = d;
        @(negedge clk);
        we  = 1'b0;
        model_write(idx, d);
    endtask

    task automatic check_vs(logic [BW-1:0] ef, logic [BW-1:0] el, string req);
        compared++;
        if (vo_f !== 1'b1 || po_f !== ef) begin
            mismatched++;
            $display("FAIL %s full: valid=%b pix=%h expected valid=1 pix=%h", req, vo_f, po_f, ef);
        end
        compared++;
        if (vo_l !== 1'b1 || po_l !== el) begin
            mismatched++;
            $display("FAIL %s lite: valid=%b pix=%h expected valid=1 pix=%h", req, vo_l, po_l, el);
        end
    endtask

    task automatic check_quiet(logic [BW-1:0] ef, logic [BW-1:0] el, string req);
        compared++;
        if (vo_f !== 1'b0 || po_f !== ef || vo_l !== 1'b0 || po_l !== el) begin
            mismatched++;
            $display("FAIL %s: valid=%b/%b pix=%h/%h expected valid=0/0 pix=%h/%h",
                     req, vo_f, vo_l, po_f, po_l, ef, el);
        end
    endtask

    // streams n pixels back to back; each result is checked two cycles later
    task automatic run_burst(int n, string req);
        for (int i = 0; i < n + 2; i++) begin
            @(negedge clk);
            if (i >= 2) check_vs(expect_bus(stim[i-2], 0), expect_bus(stim[i-2], 1), req);
            if (i < n) begin
                vin = 1'b1;
                pin = stim[i];
            end else begin
                vin = 1'b0;
            end
        end
    endtask

    function automatic logic [BW-1:0] rnd_pix(bit same);
        logic [PW-1:0] a;
        a = PW'($urandom);
        if (same) return {a, a, a};
        return BW'({$urandom, $urandom});
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        mismatched++;
        compared++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int bnd [14];
        logic [BW-1:0] p1, ef_old, el_old, last_f, last_l;
        void'($urandom(32'h0c0ffee5));
        model_reset();

        // R12: quiet during and right after reset
        repeat (3) @(negedge clk);
        check_quiet('0, '0, "R12 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_quiet('0, '0, "R12 after reset");

        // R1, R5, R3, R4, R9: segment boundaries on the reset curve
        bnd = '{0, 15, 16, 31, 32, 63, 64, 127, 128, 191, 192, 895, 896, 1023};
        for (int i = 0; i < 14; i++)
            stim[i] = {PW'(bnd[i]), PW'(bnd[(i+5)%14]), PW'(bnd[(i+9)%14])};
        run_burst(14, "R1 R5 R4 boundaries");

        // R3, R11: random pixels, some with equal components
        for (int i = 0; i < 40; i++) stim[i] = rnd_pix(i % 4 == 0);
        run_burst(40, "R3 R11 random default");

        // R2, R8: new words, including middle segments the lite variant ignores
        cfg_write(0,  {16'h0400, 16'h0005});
        cfg_write(2,  {16'h0000, 16'h0123});
        cfg_write(6,  {16'h0180, 16'h0050});
        cfg_write(9,  {16'h0040, 16'h0200});
        cfg_write(16, {16'h0080, 16'h0300});
        cfg_write(17, {16'h1000, 16'h03F0});
        stim[0] = {10'd0,   10'd15,  10'd7};
        stim[1] = {10'd32,  10'd63,  10'd40};
        stim[2] = {10'd256, 10'd319, 10'd300};
        stim[3] = {10'd448, 10'd511, 10'd470};
        stim[4] = {10'd896, 10'd959, 10'd900};
        stim[5] = {10'd960, 10'd961, 10'd1023};
        for (int i = 6; i < 30; i++) stim[i] = rnd_pix(i % 5 == 0);
        run_burst(30, "R2 R8 R4 after writes");

        // R7: out-of-range indices change nothing
        for (int k = 18; k < 32; k++) cfg_write(k, $urandom);
        for (int i = 0; i < 24; i++) stim[i] = rnd_pix(1'b0);
        run_burst(24, "R7 ignored index");

        // R6: a write in the same cycle as a pixel is seen only by the next one
        p1 = {10'd9, 10'd3, 10'd12};
        ef_old = expect_bus(p1, 0);
        el_old = expect_bus(p1, 1);
        @(negedge clk);
        vin = 1'b1; pin = p1; we = 1'b1; sel = 5'd0; wd = {16'h0200, 16'h0011};
        @(negedge clk);
        we = 1'b0;
        model_write(0, {16'h0200, 16'h0011});
        @(negedge clk);
        vin = 1'b0;
        check_vs(ef_old, el_old, "R6 same-cycle old value");
        @(negedge clk);
        check_vs(expect_bus(p1, 0), expect_bus(p1, 1), "R6 next pixel new value");
        last_f = expect_bus(p1, 0);
        last_l = expect_bus(p1, 1);

        // R10: output frozen while idle
        repeat (3) begin
            @(negedge clk);
            check_quiet(last_f, last_l, "R10 idle hold");
        end

        // R3: random curves and random pixels
        for (int r = 0; r < 4; r++) begin
            for (int k = 0; k < 6; k++)
                cfg_write($urandom_range(0, 19), {16'($urandom_range(0, 16'h0600)), 16'($urandom_range(0, 1100))});
            for (int i = 0; i < 32; i++) stim[i] = rnd_pix(i % 6 == 0);
            run_burst(32, "R3 random curve");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule